// File: doc/BRIEF.md
# Banked Return-Address Stack

This block holds the return addresses of a small controller core whose code space is split into two banks. Each entry is 14 bits: a 13-bit program counter and the single bank-select bit that was latched when the call or interrupt entry took place. A call or an interrupt acknowledge pushes the entry. A return pops it, and both the counter and the bank bit come back together, so execution resumes in the bank it left. The core fetches the interrupt vector from bank 0 on its own. The stack only preserves the caller's bank bit inside the pushed entry. Software cannot read the storage or the pointer.

The storage is a ring of eight slots. If the core pushes while all eight slots are in use, the new entry replaces the oldest one. The stack keeps the eight newest entries and stays full. The full flag is also used to hold off interrupt entry: a pending interrupt is granted only while the stack has a free slot. A pop from an empty stack does not move the pointer, leaves the output word unchanged and raises a sticky underflow flag.

Push and pop are single-cycle strobes that are always accepted. The stack never back-pressures, and the popped word is presented without a valid/ready exchange. It is valid from the cycle after the pop strobe and holds until the next successful pop.

Top module: `ret_stack`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `underflow` is 0, and `pop_bank`/`pop_pc` are 0.
- R2: `push` stores the entry {`push_bank`, `push_pc`}. A pop on a non-empty stack returns the most recently stored entry that has not yet been popped (last in, first out). The returned entry appears on the outputs on the clock edge that samples `pop`, and it holds until the next successful pop.
- R3: The popped word carries the bank bit and the counter as separate fields. Seen as one 14-bit value, the bank bit is bit 13 and the counter is bits 12:0. Both fields come back exactly as they were pushed.
- R4: `full` is 1 exactly when eight entries are held, and `empty` is 1 exactly when none are held.
- R5: A push while eight entries are held overwrites the oldest entry, and `full` stays 1 until a pop. The eight most recent entries can then be popped, newest first.
- R6: `irq_grant` equals `irq_pending` while `full` is 0, and it is 0 while `full` is 1. It follows its inputs in the same cycle.
- R7: A pop on an empty stack leaves the pop outputs and the pointer unchanged and sets `underflow`. `underflow` stays 1 until reset.
- R8: A push and a pop in the same cycle on a non-empty stack return the current top entry and replace it with the pushed entry. The entry count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Store the return entry this cycle |
| pop | input | 1 | Remove the top entry this cycle |
| push_pc | input | 13 | Return counter to store |
| push_bank | input | 1 | Bank bit to store |
| pop_pc | output | 13 | Counter of the last popped entry |
| pop_bank | output | 1 | Bank bit of the last popped entry |
| full | output | 1 | Eight entries held |
| empty | output | 1 | No entries held |
| underflow | output | 1 | Sticky: a pop was seen while empty |
| irq_pending | input | 1 | Interrupt wants entry |
| irq_grant | output | 1 | Interrupt entry allowed |

## Verification
The hardest case to reach from the ports is wrap-around after overflow. In that case the write pointer has lapped the ring and the oldest slots hold newer data. The stimulus pushes ten tagged entries in a row, alternating the bank bit. It then pops eight times and expects the last eight tags in reverse order, which shows that the first two were lost. The empty-pop case follows at once, and two fresh pushes and pops then show that the pointer did not move.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int PC_W = 13;
  localparam int ENT_W = PC_W + 1;

  typedef struct packed {
    logic            bank;
    logic [PC_W-1:0] pc;
  } ret_entry_t;
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic             rd_en,
  output logic             full,
  output logic             empty,
  output logic             underflow
);
  logic [IDX_W-1:0] wp_q, wp_inc, wp_dec;
  logic [CNT_W-1:0] cnt_q;
  logic             uf_q;
  logic             pop_ok;

  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign pop_ok = pop & ~empty;

  assign wp_inc = (wp_q == IDX_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
  assign wp_dec = (wp_q == '0) ? IDX_W'(DEPTH - 1) : wp_q - 1'b1;

  assign wr_en  = push;
  assign rd_en  = pop_ok;
  assign rd_idx = wp_dec;
  assign wr_idx = (push & pop_ok) ? wp_dec : wp_q;
  assign underflow = uf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      if (pop & empty) uf_q <= 1'b1;
      if (push && !pop_ok) begin
        wp_q <= wp_inc;
        if (!full) cnt_q <= cnt_q + 1'b1;
      end else if (pop_ok && !push) begin
        wp_q  <= wp_dec;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> full);
  // R4
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> !full);
  // R7
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> underflow);
  // R7
  uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R7
  uf_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (empty && $stable(wp_q)));
  // R8
  both_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ret_entry_t       wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ret_entry_t       rd_data
);
  ret_entry_t slot [DEPTH];
  ret_entry_t rd_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) slot[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_en) rd_q <= slot[rd_idx];
  end

  assign rd_data = rd_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_pc,
  input  logic            push_bank,
  output logic [PC_W-1:0] pop_pc,
  output logic            pop_bank,
  output logic            full,
  output logic            empty,
  output logic            underflow,
  input  logic            irq_pending,
  output logic            irq_grant
);
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_en, rd_en;
  ret_entry_t       wr_ent, rd_ent;

  assign wr_ent.bank = push_bank;
  assign wr_ent.pc   = push_pc;

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .underflow(underflow)
  );

  ret_stack_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_ent), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_ent)
  );

  assign pop_pc    = rd_ent.pc;
  assign pop_bank  = rd_ent.bank;
  assign irq_grant = irq_pending & ~full;

  // R7
  uf_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable({pop_bank, pop_pc}));
  // R6
  irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> !irq_grant);
endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0, push_bank = 1'b0, irq_pending = 1'b0;
  logic [12:0] push_pc = '0;
  logic [12:0] pop_pc;
  logic pop_bank, full, empty, underflow, irq_grant;

  int total = 0;
  int bad = 0;

  always #(CLK_T/2) clk = ~clk;

  ret_stack u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_pc(push_pc), .push_bank(push_bank),
    .pop_pc(pop_pc), .pop_bank(pop_bank),
    .full(full), .empty(empty), .underflow(underflow),
    .irq_pending(irq_pending), .irq_grant(irq_grant)
  );

  // [31] push [30] pop [29] bank [28:16] pc [15:2] expected word [1] empty [0] full
  localparam logic [31:0] VEC [0:7] = '{
    {1'b1, 1'b0, 1'b0, 13'h0123, 14'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 13'h0456, 14'h0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 13'h0000, 14'h2456, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 13'h1FFF, 14'h2456, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 13'h0AAA, 14'h3FFF, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 13'h0000, 14'h0AAA, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 13'h0000, 14'h0123, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 13'h0000, 14'h0123, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic q, input logic b, input logic [12:0] a);
    push = p; pop = q; push_bank = b; push_pc = a;
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  function automatic logic [13:0] tag(input int i);
    return {1'(i % 2), 13'(13'h100 + i)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 full", 32'(full), 32'd0);
    check("R1 underflow", 32'(underflow), 32'd0);
    check("R1 word", 32'({pop_bank, pop_pc}), 32'd0);

    // R2 R3 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28:16]);
      check($sformatf("R2/R3/R8 row%0d word", i), 32'({pop_bank, pop_pc}), 32'(VEC[i][15:2]));
      check($sformatf("R4 row%0d empty", i), 32'(empty), 32'(VEC[i][1]));
      check($sformatf("R4 row%0d full", i), 32'(full), 32'(VEC[i][0]));
    end

    // R5 overflow: ten pushes, oldest two lost
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b0, tag(i)[13], tag(i)[12:0]);
      if (i == 6) check("R4 not full at 7", 32'(full), 32'd0);
    end
    check("R5 full after overflow", 32'(full), 32'd1);
    irq_pending = 1'b1;
    #1 check("R6 grant blocked", 32'(irq_grant), 32'd0);
    for (int i = 9; i >= 2; i--) begin
      cyc(1'b0, 1'b1, 1'b0, 13'h0);
      check($sformatf("R5 pop tag%0d", i), 32'({pop_bank, pop_pc}), 32'(tag(i)));
      if (i == 9) begin
        check("R4 full drops", 32'(full), 32'd0);
        #1 check("R6 grant open", 32'(irq_grant), 32'd1);
      end
    end
    irq_pending = 1'b0;
    #1 check("R6 grant idle", 32'(irq_grant), 32'd0);
    check("R4 empty after drain", 32'(empty), 32'd1);

    // R7 pop while empty
    cyc(1'b0, 1'b1, 1'b0, 13'h0);
    check("R7 word held", 32'({pop_bank, pop_pc}), 32'(tag(2)));
    check("R7 underflow set", 32'(underflow), 32'd1);
    check("R7 still empty", 32'(empty), 32'd1);
    cyc(1'b1, 1'b0, 1'b1, 13'h0ABC);
    cyc(1'b1, 1'b0, 1'b0, 13'h1234);
    cyc(1'b0, 1'b1, 1'b0, 13'h0);
    check("R7 ptr unchanged b", 32'({pop_bank, pop_pc}), 32'h1234);
    cyc(1'b0, 1'b1, 1'b0, 13'h0);
    check("R7 ptr unchanged a", 32'({pop_bank, pop_pc}), 32'h2ABC);
    check("R7 empty again", 32'(empty), 32'd1);
    check("R7 sticky", 32'(underflow), 32'd1);

    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    check("R1 underflow cleared", 32'(underflow), 32'd0);
    check("R1 word cleared", 32'({pop_bank, pop_pc}), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule